// File: doc/BRIEF.md
# Open-Loop Ramp Rate Calibrator

This block tunes the open-loop acceleration of a sensorless spindle start-up. The ramp current that pushes the VCO input up during open-loop stepping comes from a PWM output. Tolerances in the analog parts make the actual ramp rate differ from the intended one. The calibrator corrects for this by driving a measurement run and then picking a new duty cycle.

On a start request it holds the motor controller's reset input low for a fixed number of clocks. It then releases that reset, forces the current command to zero and drives the ramp PWM at exactly half duty. It times the first two complete VCO periods that follow the release. The shrinkage from the first period to the second is the achieved ramp. This is compared with a target period shrinkage. The new duty is half scale multiplied by target over measured. A multi-cycle restoring divider computes it, and the result is limited to roughly 1 % to 99 %. From then on that duty drives the PWM. A run that measures no acceleration flags an error and leaves the previous duty in place.

Top module: `ramp_cal`

## Requirements
- R1: After a start request is accepted while idle, `ctrl_rst_no` is low for exactly `RST_CYC` consecutive clocks. The default is 250, which is 5 µs at 50 MHz.
- R2: `icmd_zero_o` is 1 for the whole calibration, from the reset hold until the result is applied. It is 0 when idle.
- R3: Throughout calibration the PWM is high for exactly 128 of every 256 consecutive clocks, which is 50 %.
- R4: Only VCO rising edges after the controller reset is released count. The periods used are the first two complete periods: edge 1 to edge 2 (T1) and edge 2 to edge 3 (T2). Edges during the reset hold are ignored.
- R5: With T1 > T2, the new duty is floor(128 × target / (T1 − T2)) on a 256-step scale.
- R6: The new duty is clamped to the range 3..253.
- R7: If T1 ≤ T2, `err_o` goes to 1, `valid_o` stays 0 and `duty_o` keeps its previous value. `valid_o` and `err_o` are never both 1.
- R8: After calibration, the PWM is high for exactly `duty_o` of every 256 consecutive clocks. `duty_o` does not change while `busy_o` is 1, except on the cycle the result is applied.
- R9: A start request while `busy_o` is 1 is ignored. The controller reset is not reasserted during that run.
- R10: After `rst_ni` is released, `duty_o` is 128 and `ctrl_rst_no` is 1. `icmd_zero_o`, `busy_o`, `valid_o` and `err_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start calibration (single-cycle pulse) |
| vco_i | input | 1 | VCO output of the motor controller, synchronous to clk_i |
| target_diff_i | input | CNT_W | Desired T1 − T2 in clocks |
| ctrl_rst_no | output | 1 | Active-low reset to the motor controller |
| icmd_zero_o | output | 1 | Forces the motor current command to zero |
| pwm_o | output | 1 | Ramp-current PWM |
| duty_o | output | DUTY_W | Duty applied outside calibration (out of 256) |
| busy_o | output | 1 | Calibration in progress |
| valid_o | output | 1 | Last run produced a new duty |
| err_o | output | 1 | Last run saw no acceleration |

## Verification
The hardest condition to reach is a measurement in which stray VCO activity precedes the counted periods. This can be edges during the reset hold, or a restart request arriving in the middle of a run. Either one would shift which periods are timed. The bench toggles `vco_i` throughout the reset hold in one scenario. In another it pulses `start_i` after release but before the first counted edge. In both it then checks that the result matches the periods it drove afterwards. Clamp and error paths are reached by choosing the target and the drawn periods so that the ratio lands above 253, below 3, or the periods stay equal or grow.

// File: rtl/ramp_cal_pkg.sv
package ramp_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RST,
    ST_MEAS,
    ST_DIV
  } cal_st_e;
endpackage

// File: rtl/ramp_pwm.sv
module ramp_pwm #(
  parameter int DUTY_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [DUTY_W-1:0] duty_i,
  output logic              pwm_o
);
  logic [DUTY_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      pwm_o <= 1'b0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
      pwm_o <= (cnt_q < duty_i);
    end
  end
endmodule

// File: rtl/ramp_period_meter.sv
module ramp_period_meter #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             vco_i,
  output logic             done_o,
  output logic [CNT_W-1:0] t1_o,
  output logic [CNT_W-1:0] t2_o
);
  logic             vco_q;
  logic             rise;
  logic [1:0]       phase_q;
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_inc;

  assign rise    = vco_i & ~vco_q;
  assign cnt_inc = (cnt_q == '1) ? cnt_q : cnt_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vco_q   <= 1'b0;
      phase_q <= 2'd0;
      cnt_q   <= '0;
      t1_o    <= '0;
      t2_o    <= '0;
      done_o  <= 1'b0;
    end else begin
      vco_q  <= vco_i;
      done_o <= 1'b0;
      if (arm_i) begin
        phase_q <= 2'd1;
      end else begin
        unique case (phase_q)
          2'd1: if (rise) begin
            cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
            phase_q <= 2'd2;
          end
          2'd2: if (rise) begin
            t1_o    <= cnt_q;
            cnt_q   <= {{(CNT_W-1){1'b0}}, 1'b1};
            phase_q <= 2'd3;
          end else cnt_q <= cnt_inc;
          2'd3: if (rise) begin
            t2_o    <= cnt_q;
            phase_q <= 2'd0;
            done_o  <= 1'b1;
          end else cnt_q <= cnt_inc;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ramp_div.sv
module ramp_div #(
  parameter int NUM_W = 23,
  parameter int DEN_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [NUM_W-1:0] num_i,
  input  logic [DEN_W-1:0] den_i,
  output logic             done_o,
  output logic [NUM_W-1:0] quo_o
);
  localparam int CW = $clog2(NUM_W + 1);

  logic [DEN_W-1:0] rem_q, den_q;
  logic [CW-1:0]    it_q;
  logic             run_q;
  logic [DEN_W:0]   shifted;
  logic             ge;

  assign shifted = {rem_q, quo_o[NUM_W-1]};
  assign ge      = shifted >= {1'b0, den_q};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rem_q  <= '0;
      den_q  <= '0;
      quo_o  <= '0;
      it_q   <= '0;
      run_q  <= 1'b0;
      done_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (start_i) begin
        rem_q <= '0;
        quo_o <= num_i;
        den_q <= den_i;
        it_q  <= '0;
        run_q <= 1'b1;
      end else if (run_q) begin
        rem_q <= ge ? DEN_W'(shifted - {1'b0, den_q}) : shifted[DEN_W-1:0];
        quo_o <= {quo_o[NUM_W-2:0], ge};
        if (it_q == CW'(NUM_W - 1)) begin
          run_q  <= 1'b0;
          done_o <= 1'b1;
        end else begin
          it_q <= it_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/ramp_cal.sv
module ramp_cal
  import ramp_cal_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int DUTY_W  = 8,
  parameter int RST_CYC = 250
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              vco_i,
  input  logic [CNT_W-1:0]  target_diff_i,
  output logic              ctrl_rst_no,
  output logic              icmd_zero_o,
  output logic              pwm_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              busy_o,
  output logic              valid_o,
  output logic              err_o
);
  localparam int STEPS    = 1 << DUTY_W;
  localparam int HALF     = STEPS / 2;
  localparam int DUTY_MIN = (STEPS + 99) / 100;
  localparam int DUTY_MAX = STEPS - DUTY_MIN;
  localparam int NUM_W    = CNT_W + DUTY_W - 1;
  localparam int RC_W     = $clog2(RST_CYC + 1);

  cal_st_e           st_q;
  logic [RC_W-1:0]   rc_q;
  logic              arm_q, div_go_q;
  logic              m_done, d_done;
  logic [CNT_W-1:0]  t1, t2;
  logic [NUM_W-1:0]  quo;
  logic [DUTY_W-1:0] duty_q, duty_new, pwm_duty;

  assign busy_o      = (st_q != ST_IDLE);
  assign icmd_zero_o = busy_o;
  assign ctrl_rst_no = (st_q != ST_RST);
  assign duty_o      = duty_q;
  assign pwm_duty    = busy_o ? DUTY_W'(HALF) : duty_q;

  always_comb begin
    if (quo > NUM_W'(DUTY_MAX))      duty_new = DUTY_W'(DUTY_MAX);
    else if (quo < NUM_W'(DUTY_MIN)) duty_new = DUTY_W'(DUTY_MIN);
    else                             duty_new = quo[DUTY_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q     <= ST_IDLE;
      rc_q     <= '0;
      arm_q    <= 1'b0;
      div_go_q <= 1'b0;
      duty_q   <= DUTY_W'(HALF);
      valid_o  <= 1'b0;
      err_o    <= 1'b0;
    end else begin
      arm_q    <= 1'b0;
      div_go_q <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start_i) begin
          st_q    <= ST_RST;
          rc_q    <= '0;
          valid_o <= 1'b0;
          err_o   <= 1'b0;
        end
        ST_RST: if (rc_q == RC_W'(RST_CYC - 1)) begin
          st_q  <= ST_MEAS;
          arm_q <= 1'b1;
        end else begin
          rc_q <= rc_q + 1'b1;
        end
        ST_MEAS: if (m_done) begin
          if (t1 > t2) begin
            div_go_q <= 1'b1;
            st_q     <= ST_DIV;
          end else begin
            err_o <= 1'b1;
            st_q  <= ST_IDLE;
          end
        end
        ST_DIV: if (d_done) begin
          duty_q  <= duty_new;
          valid_o <= 1'b1;
          st_q    <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  ramp_period_meter #(.CNT_W(CNT_W)) u_meter (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .arm_i (arm_q),
    .vco_i (vco_i),
    .done_o(m_done),
    .t1_o  (t1),
    .t2_o  (t2)
  );

  ramp_div #(.NUM_W(NUM_W), .DEN_W(CNT_W)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(div_go_q),
    .num_i  ({target_diff_i, {(DUTY_W-1){1'b0}}}),
    .den_i  (t1 - t2),
    .done_o (d_done),
    .quo_o  (quo)
  );

  ramp_pwm #(.DUTY_W(DUTY_W)) u_pwm (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .duty_i(pwm_duty),
    .pwm_o (pwm_o)
  );
endmodule

// File: rtl/ramp_cal_chk.sv
module ramp_cal_chk #(
  parameter int DUTY_W  = 8,
  parameter int RST_CYC = 250
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              ctrl_rst_no,
  input logic              icmd_zero_o,
  input logic [DUTY_W-1:0] duty_o,
  input logic              busy_o,
  input logic              valid_o,
  input logic              err_o
);
  localparam int STEPS    = 1 << DUTY_W;
  localparam int DUTY_MIN = (STEPS + 99) / 100;
  localparam int DUTY_MAX = STEPS - DUTY_MIN;

  int low_cnt;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          low_cnt <= 0;
    else if (!ctrl_rst_no) low_cnt <= low_cnt + 1;
    else                  low_cnt <= 0;
  end

  p_rst_len_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ctrl_rst_no) |-> (low_cnt == RST_CYC));

  p_icmd_in_rst_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_rst_no |-> icmd_zero_o);

  p_duty_range_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_o) |-> (duty_o >= DUTY_W'(DUTY_MIN) && duty_o <= DUTY_W'(DUTY_MAX)));

  p_err_keeps_duty_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(err_o) |-> $stable(duty_o));

  p_valid_err_excl_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && err_o));

  p_duty_hold_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(duty_o));

  p_no_rereset_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ctrl_rst_no) |=> (!busy_o || ctrl_rst_no));
endmodule

bind ramp_cal ramp_cal_chk #(.DUTY_W(DUTY_W), .RST_CYC(RST_CYC)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ctrl_rst_no(ctrl_rst_no),
  .icmd_zero_o(icmd_zero_o),
  .duty_o     (duty_o),
  .busy_o     (busy_o),
  .valid_o    (valid_o),
  .err_o      (err_o)
);

// File: tb/tb_ramp_cal.sv
module tb_ramp_cal;
  localparam int CNT_W   = 16;
  localparam int DUTY_W  = 8;
  localparam int RST_CYC = 250;

  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic start_i = 1'b0;
  logic vco_i = 1'b0;
  logic [CNT_W-1:0] target_diff_i = '0;
  logic ctrl_rst_no, icmd_zero_o, pwm_o, busy_o, valid_o, err_o;
  logic [DUTY_W-1:0] duty_o;

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;

  always #10 clk_i = ~clk_i;

  ramp_cal #(.CNT_W(CNT_W), .DUTY_W(DUTY_W), .RST_CYC(RST_CYC)) dut (.*);

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int exp_duty(input int target, input int diff);
    int q;
    q = (target * 128) / diff;
    if (q > 253) q = 253;
    if (q < 3) q = 3;
    return q;
  endfunction

  task automatic count_pwm(output int highs);
    highs = 0;
    for (int i = 0; i < 256; i++) begin
      @(negedge clk_i);
      if (pwm_o) highs++;
    end
  endtask

  task automatic vco_train(input int p1, input int p2);
    int per[2];
    per[0] = p1;
    per[1] = p2;
    for (int k = 0; k < 2; k++) begin
      vco_i = 1'b1;
      repeat (2) @(negedge clk_i);
      vco_i = 1'b0;
      repeat (per[k] - 2) @(negedge clk_i);
    end
    vco_i = 1'b1;
    repeat (2) @(negedge clk_i);
    vco_i = 1'b0;
  endtask

  // noise: toggle vco during reset hold; restart: pulse start after release
  task automatic run_cal(input int target, input int p1, input int p2, input bit noise,
                         input bit restart, input bit half_chk, output int lowc);
    int w;
    int highs;
    target_diff_i = CNT_W'(target);
    @(negedge clk_i) start_i = 1'b1;
    @(negedge clk_i) start_i = 1'b0;
    lowc = 0;
    while (!ctrl_rst_no && lowc < 2000) begin
      if (!icmd_zero_o) check(1'b0, "R2 icmd_zero in reset hold", 0, 1);
      lowc++;
      if (noise) vco_i = ((lowc % 20) < 10);
      @(negedge clk_i);
    end
    vco_i = 1'b0;
    repeat (4) @(negedge clk_i);
    if (restart) begin
      start_i = 1'b1;
      @(negedge clk_i) start_i = 1'b0;
      for (int i = 0; i < 6; i++) begin
        check(ctrl_rst_no == 1'b1, "R9 no re-reset while busy", int'(ctrl_rst_no), 1);
        @(negedge clk_i);
      end
    end
    if (half_chk) begin
      count_pwm(highs);
      check(highs == 128, "R3 half duty during calibration", highs, 128);
      check(icmd_zero_o == 1'b1, "R2 icmd_zero during measurement", int'(icmd_zero_o), 1);
    end
    vco_train(p1, p2);
    w = 0;
    while (busy_o && w < 500) begin
      @(negedge clk_i);
      w++;
    end
    check(!busy_o, "R5 calibration completes", int'(busy_o), 0);
  endtask

  task automatic t_reset_state();
    check(duty_o == 128, "R10 reset duty", duty_o, 128);
    check(ctrl_rst_no == 1'b1, "R10 reset ctrl_rst_no", int'(ctrl_rst_no), 1);
    check(!icmd_zero_o && !busy_o, "R10 reset icmd/busy", int'(icmd_zero_o | busy_o), 0);
    check(!valid_o && !err_o, "R10 reset valid/err", int'(valid_o | err_o), 0);
  endtask

  task automatic t_nominal();
    int lowc;
    run_cal(10, 200, 190, 1'b0, 1'b0, 1'b1, lowc);
    check(lowc == RST_CYC, "R1 reset hold length", lowc, RST_CYC);
    check(duty_o == exp_duty(10, 10), "R5 nominal ratio", duty_o, exp_duty(10, 10));
    check(valid_o && !err_o, "R5 valid set", int'(valid_o), 1);
    check(!icmd_zero_o, "R2 icmd released when idle", int'(icmd_zero_o), 0);
  endtask

  task automatic t_ratio(input int target, input int p1, input int p2, input string req);
    int lowc;
    int highs;
    int e;
    e = exp_duty(target, p1 - p2);
    run_cal(target, p1, p2, 1'b0, 1'b0, 1'b0, lowc);
    check(duty_o == e, req, duty_o, e);
    check(valid_o && !err_o, req, int'(valid_o), 1);
    count_pwm(highs);
    check(highs == e, "R8 PWM follows new duty", highs, e);
  endtask

  task automatic t_error(input int p1, input int p2);
    int lowc;
    int prev;
    prev = duty_o;
    run_cal(20, p1, p2, 1'b0, 1'b0, 1'b0, lowc);
    check(err_o == 1'b1, "R7 error flag", int'(err_o), 1);
    check(valid_o == 1'b0, "R7 valid stays low", int'(valid_o), 0);
    check(duty_o == prev, "R7 duty kept", duty_o, prev);
  endtask

  task automatic t_noise();
    int lowc;
    run_cal(15, 200, 190, 1'b1, 1'b0, 1'b0, lowc);
    check(lowc == RST_CYC, "R1 reset hold length with noise", lowc, RST_CYC);
    check(duty_o == exp_duty(15, 10), "R4 edges in reset ignored", duty_o, exp_duty(15, 10));
  endtask

  task automatic t_restart();
    int lowc;
    run_cal(12, 250, 238, 1'b0, 1'b1, 1'b0, lowc);
    check(duty_o == exp_duty(12, 12), "R9 restart ignored result", duty_o, exp_duty(12, 12));
    check(valid_o == 1'b1, "R9 valid after ignored restart", int'(valid_o), 1);
  endtask

  initial begin
    forever begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected < 150000 cycles", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    t_reset_state();
    t_nominal();
    t_ratio(5, 200, 190, "R5 halved duty");
    t_ratio(7, 300, 287, "R5 fractional ratio");
    t_ratio(40, 200, 190, "R6 clamp high");
    t_ratio(1, 400, 200, "R6 clamp low");
    t_error(150, 150);
    t_error(150, 160);
    t_noise();
    t_restart();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule